// File: doc/BRIEF.md
# Redundant-Radix Limb Carry Normalizer

This block holds a multi-precision number as an array of wide accumulator limbs. Each limb is `ACC_W` bits wide, but only the low `DIG_W` bits are significant once the number is in normal form. The remaining `ACC_W - DIG_W` guard bits absorb the growth from repeated multiply-accumulate passes, which a datapath outside this block performs. When software or a sequencer pulses `start`, the block walks the limbs from the least significant to the most significant. It folds each limb's excess above `DIG_W` bits into the next limb, so every limb ends up below `2^DIG_W`. The excess that leaves the top limb appears on a separate output. The boundary between significant and guard bits may fall at any bit position, so it need not sit on a byte edge.

A host port reads and writes the limb buffer while the block is idle. An accumulate-event input counts the passes added into the limbs since the last normalization. The block raises a request once the guard bits are close to exhausted, so that a normalization can be scheduled before any limb wraps.

Top module: `limb_carry_norm`

## Requirements
- R1: After reset, `busy`, `done`, `norm_req` and `carry_out` are all zero.
- R2: After a normalization, limb i holds bits [DIG_W*(i+1)-1 : DIG_W*i] of the value V = sum over i of limb_i * 2^(DIG_W*i), taken from the limbs before the run, and all of its bits at or above DIG_W are zero.
- R3: `carry_out` becomes V >> (DIG_W*NLIMB) when a normalization completes, and it holds that value until the next completion.
- R4: `done` is high for exactly one cycle, 2*NLIMB clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until `done` rises, and it is low while `done` is high.
- R5: A `start` seen while `busy` is high is ignored. It causes no restart, no change in latency and no second `done`.
- R6: A host write while `busy` is high has no effect on the buffer.
- R7: While idle, a host write stores `host_wdata` at `host_addr`. A read returns the limb at `host_addr` on `host_rdata` one edge after the address is presented.
- R8: Each cycle with `acc_evt` high is one accumulation. `norm_req` is registered, and it rises at the edge that counts accumulation number 2^G - 2 since the last completion, where G = ACC_W - DIG_W.
- R9: The accumulation count saturates at 2^G - 2. Once `norm_req` is high, it stays high through further events until a normalization completes.
- R10: A completing normalization clears the count and drops `norm_req` at the edge that raises `done`. An `acc_evt` in that same cycle counts as the first accumulation of the new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a normalization (accepted only when idle) |
| busy | output | 1 | Normalization in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | ACC_W-DIG_W+1 | Carry out of the most significant limb from the last run |
| host_addr | input | clog2(NLIMB) | Limb index for host read and write |
| host_we | input | 1 | Host write enable (ignored while busy) |
| host_wdata | input | ACC_W | Host write data |
| host_rdata | output | ACC_W | Limb read data, one cycle after the address |
| acc_evt | input | 1 | One accumulation pass was added into the limbs |
| norm_req | output | 1 | Guard headroom is nearly exhausted |

## Verification
The bench runs on a 4-limb, 16-bit configuration with a 12-bit significant width, which puts the split away from any byte edge. It sweeps several hundred limb patterns, including all-ones limbs and digit chains that sit exactly at 2^12 - 1 and ripple one carry across every limb. An engine that dropped the carry-in, split at the wrong bit or discarded the top carry would give wrong limbs or a wrong `carry_out`. The headroom counter is stepped through each count from 1 to past the limit. This exposes an off-by-one threshold, a counter that wraps and lowers the request again, and a clear that loses an event arriving in the completion cycle. A second `start` and a host write injected mid-run catch an engine that restarts or lets the host corrupt a limb that has already been normalized.

// File: rtl/lcn_pkg.sv
package lcn_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_READ = 2'd1,
    WALK_CALC = 2'd2
  } walk_state_t;
endpackage

// File: rtl/lcn_ram.sv
module lcn_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 128,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/lcn_split.sv
module lcn_split #(
  parameter int ACC_W = 128,
  parameter int DIG_W = 112,
  localparam int CARRY_W = ACC_W - DIG_W + 1,
  localparam int SUM_W = ACC_W + 1
) (
  input  logic [ACC_W-1:0]   limb,
  input  logic [CARRY_W-1:0] cin,
  output logic [ACC_W-1:0]   digit,
  output logic [CARRY_W-1:0] cout
);
  logic [SUM_W-1:0] total;

  always_comb begin
    total = {1'b0, limb} + {{(SUM_W-CARRY_W){1'b0}}, cin};
    digit = {{(ACC_W-DIG_W){1'b0}}, total[DIG_W-1:0]};
    cout  = total[SUM_W-1:DIG_W];
  end
endmodule

// File: rtl/lcn_walker.sv
module lcn_walker
  import lcn_pkg::*;
#(
  parameter int NLIMB = 8,
  parameter int ACC_W = 128,
  parameter int DIG_W = 112,
  localparam int AW = (NLIMB > 1) ? $clog2(NLIMB) : 1,
  localparam int CARRY_W = ACC_W - DIG_W + 1,
  localparam logic [AW-1:0] TOP = AW'(NLIMB - 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ACC_W-1:0]   rd_limb,
  output logic [AW-1:0]      rd_idx,
  output logic               wr_en,
  output logic [AW-1:0]      wr_idx,
  output logic [ACC_W-1:0]   wr_limb,
  output logic               busy,
  output logic               done,
  output logic               finish,
  output logic [CARRY_W-1:0] carry_out
);
  walk_state_t        state;
  logic [AW-1:0]      idx;
  logic [CARRY_W-1:0] carry;
  logic [CARRY_W-1:0] carry_nxt;
  logic [ACC_W-1:0]   digit;

  lcn_split #(.ACC_W(ACC_W), .DIG_W(DIG_W)) u_split (
    .limb (rd_limb),
    .cin  (carry),
    .digit(digit),
    .cout (carry_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WALK_IDLE;
      idx       <= '0;
      carry     <= '0;
      done      <= 1'b0;
      carry_out <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        WALK_IDLE: begin
          if (start) begin
            state <= WALK_READ;
            idx   <= '0;
            carry <= '0;
          end
        end
        WALK_READ: state <= WALK_CALC;
        WALK_CALC: begin
          carry <= carry_nxt;
          if (idx == TOP) begin
            state     <= WALK_IDLE;
            done      <= 1'b1;
            carry_out <= carry_nxt;
          end else begin
            idx   <= idx + 1'b1;
            state <= WALK_READ;
          end
        end
        default: state <= WALK_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_idx  = idx;
    wr_idx  = idx;
    wr_en   = (state == WALK_CALC);
    wr_limb = digit;
    busy    = (state != WALK_IDLE);
    finish  = (state == WALK_CALC) && (idx == TOP);
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R4
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !finish) |=> (busy && !done)); // R5
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(carry_out)); // R3
endmodule

// File: rtl/lcn_headroom.sv
module lcn_headroom #(
  parameter int GUARD = 16,
  localparam logic [GUARD-1:0] LIMIT = {{(GUARD-1){1'b1}}, 1'b0}
) (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clear,
  output logic req
);
  logic [GUARD-1:0] count;
  logic [GUARD-1:0] count_nxt;

  always_comb begin
    if (clear)
      count_nxt = evt ? GUARD'(1) : '0;
    else if (evt && count != LIMIT)
      count_nxt = count + 1'b1;
    else
      count_nxt = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      req   <= 1'b0;
    end else begin
      count <= count_nxt;
      req   <= (count_nxt == LIMIT);
    end
  end

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst) (req && !clear) |=> req); // R9
  AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (rst) clear |=> !req); // R10
endmodule

// File: rtl/limb_carry_norm.sv
module limb_carry_norm #(
  parameter int NLIMB = 8,
  parameter int ACC_W = 128,
  parameter int DIG_W = 112,
  localparam int AW = (NLIMB > 1) ? $clog2(NLIMB) : 1,
  localparam int GUARD = ACC_W - DIG_W,
  localparam int CARRY_W = GUARD + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [CARRY_W-1:0] carry_out,
  input  logic [AW-1:0]      host_addr,
  input  logic               host_we,
  input  logic [ACC_W-1:0]   host_wdata,
  output logic [ACC_W-1:0]   host_rdata,
  input  logic               acc_evt,
  output logic               norm_req
);
  logic [AW-1:0]    eng_rd_idx;
  logic [AW-1:0]    eng_wr_idx;
  logic             eng_we;
  logic [ACC_W-1:0] eng_wdata;
  logic             finish;
  logic             ram_we;
  logic [AW-1:0]    ram_waddr;
  logic [ACC_W-1:0] ram_wdata;
  logic [AW-1:0]    ram_raddr;
  logic [ACC_W-1:0] ram_rdata;

  always_comb begin
    ram_we    = eng_we | (host_we & ~busy);
    ram_waddr = busy ? eng_wr_idx : host_addr;
    ram_wdata = busy ? eng_wdata : host_wdata;
    ram_raddr = busy ? eng_rd_idx : host_addr;
    host_rdata = ram_rdata;
  end

  lcn_ram #(.DEPTH(NLIMB), .WIDTH(ACC_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(ram_raddr),
    .rdata(ram_rdata)
  );

  lcn_walker #(.NLIMB(NLIMB), .ACC_W(ACC_W), .DIG_W(DIG_W)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_limb  (ram_rdata),
    .rd_idx   (eng_rd_idx),
    .wr_en    (eng_we),
    .wr_idx   (eng_wr_idx),
    .wr_limb  (eng_wdata),
    .busy     (busy),
    .done     (done),
    .finish   (finish),
    .carry_out(carry_out)
  );

  lcn_headroom #(.GUARD(GUARD)) u_head (
    .clk  (clk),
    .rst  (rst),
    .evt  (acc_evt),
    .clear(finish),
    .req  (norm_req)
  );

  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_we) |-> !ram_we); // R6
  AST_REQ_LOW_AT_DONE: assert property (@(posedge clk) disable iff (rst) done |-> !norm_req); // R10
endmodule

// File: tb/limb_carry_norm_tb.sv
module limb_carry_norm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int AW_T = 16;
  localparam int DW_T = 12;
  localparam int CW = AW_T - DW_T + 1;
  localparam int LIMIT = (1 << (AW_T - DW_T)) - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, norm_req;
  logic [CW-1:0] carry_out;
  logic [1:0] host_addr = '0;
  logic host_we = 1'b0;
  logic [AW_T-1:0] host_wdata = '0;
  logic [AW_T-1:0] host_rdata;
  logic acc_evt = 1'b0;

  int total = 0;
  int bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  limb_carry_norm #(.NLIMB(NL), .ACC_W(AW_T), .DIG_W(DW_T)) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .carry_out(carry_out), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .acc_evt(acc_evt),
    .norm_req(norm_req)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic wr(input int a, input logic [AW_T-1:0] d);
    host_addr = a[1:0]; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [AW_T-1:0] d);
    host_addr = a[1:0];
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic run_norm(input int mode, output int lat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      start = (mode == 1 && lat == 3);
      if (mode == 2 && lat == 5) begin
        host_we = 1'b1; host_addr = 2'd0; host_wdata = 16'hABCD;
      end else host_we = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0; host_we = 1'b0;
  endtask

  task automatic do_pattern(input logic [AW_T-1:0] l0, input logic [AW_T-1:0] l1,
                            input logic [AW_T-1:0] l2, input logic [AW_T-1:0] l3, input int mode);
    logic [AW_T-1:0] lim [NL];
    longint unsigned v;
    int lat;
    logic [AW_T-1:0] got;
    lim[0] = l0; lim[1] = l1; lim[2] = l2; lim[3] = l3;
    v = 0;
    for (int i = 0; i < NL; i++) begin
      wr(i, lim[i]);
      v += longint'(lim[i]) << (DW_T * i);
    end
    run_norm(mode, lat);
    chk(lat == 2*NL, "R4 latency", lat, 2*NL);
    chk(busy == 1'b0, "R4 busy low at done", busy, 0);
    chk(carry_out == CW'(v >> (DW_T*NL)), "R3 carry_out", carry_out, v >> (DW_T*NL));
    @(negedge clk);
    chk(done == 1'b0, "R4 done one cycle", done, 0);
    for (int i = 0; i < NL; i++) begin
      rd(i, got);
      chk(got == AW_T'((v >> (DW_T*i)) & ((1 << DW_T) - 1)),
          (mode == 2 && i == 0) ? "R6 host write blocked" : "R2 limb digit",
          got, (v >> (DW_T*i)) & ((1 << DW_T) - 1));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW_T-1:0] got;
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(norm_req == 0, "R1 norm_req", norm_req, 0);
    chk(carry_out == 0, "R1 carry_out", carry_out, 0);

    // R7 plain write/read while idle
    for (int i = 0; i < NL; i++) wr(i, AW_T'(16'h1357 + i * 16'h1111));
    for (int i = 0; i < NL; i++) begin
      rd(i, got);
      chk(got == AW_T'(16'h1357 + i * 16'h1111), "R7 host readback", got, 16'h1357 + i * 16'h1111);
    end

    // R8/R9 headroom sweep
    for (int k = 1; k <= LIMIT + 6; k++) begin
      acc_evt = 1'b1;
      @(negedge clk);
      acc_evt = 1'b0;
      if (k <= LIMIT) chk(norm_req == (k >= LIMIT), "R8 request threshold", norm_req, k >= LIMIT);
      else chk(norm_req == 1'b1, "R9 request sticky", norm_req, 1);
    end

    // corner patterns (R2, R3)
    do_pattern(16'h0000, 16'h0000, 16'h0000, 16'h0000, 0);
    chk(norm_req == 1'b0, "R10 request cleared", norm_req, 0);
    do_pattern(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0);
    do_pattern(16'h1FFF, 16'h0FFF, 16'h0FFF, 16'h0FFF, 0);
    do_pattern(16'h0FFF, 16'h0FFF, 16'h0FFF, 16'h0FFF, 0);
    do_pattern(16'h1000, 16'h2000, 16'h4000, 16'h8000, 0);
    do_pattern(16'h0ABC, 16'h0123, 16'h0456, 16'h0789, 0);

    // R5 second start mid-run, R6 host write mid-run
    do_pattern(16'hF00F, 16'h7FF7, 16'h3003, 16'hE001, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R5 no restart", {busy, done}, 0);
    end
    do_pattern(16'hFFFF, 16'h1234, 16'hF0F0, 16'h0F0F, 2);

    // R10 event coinciding with completion counts as one
    acc_evt = 1'b1;
    run_norm(0, lat);
    acc_evt = 1'b0;
    chk(norm_req == 1'b0, "R10 low at done", norm_req, 0);
    for (int k = 2; k <= LIMIT; k++) begin
      acc_evt = 1'b1;
      @(negedge clk);
      acc_evt = 1'b0;
      chk(norm_req == (k >= LIMIT), "R10 carried event", norm_req, k >= LIMIT);
    end

    // random sweep
    for (int p = 0; p < 300; p++) begin
      logic [AW_T-1:0] a, b, c, d;
      seed = nxt(seed); a = seed[15:0]; b = seed[31:16];
      seed = nxt(seed); c = seed[15:0]; d = seed[31:16];
      if (p % 4 == 1) begin a[15:12] = 4'h0; b = 16'h0FFF; c = 16'h0FFF; end
      do_pattern(a, b, c, d, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule